// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block supervises a processor that must prove it is alive once per pass through its main program. The processor issues a strobe by writing a control word. The supervisor accepts that strobe only inside a time window. The window opens a fixed number of clock cycles after the previous accepted strobe, or after reset release, and it closes a larger number of cycles later. A strobe that comes too soon suggests that code was skipped. A strobe that never comes before the window closes suggests that code is stuck in a loop. Either case is treated as a failure.

When a failure is found, the block latches it. It then pulls an active-low interrupt to the processor so that abnormal execution stops. One cycle later it pulls an active-low fail line. The fail line forces off the enables of two downstream output generators. The fault stays set until the next synchronous reset, and no strobe can clear it. A two-bit cause field records whether the first failure came from an early strobe or from a late or missing one.

Top module: `wdog_window`

## Requirements
- R1: A strobe is recognised only in a cycle with `ctl_wr` high and both `ctl_data[5]` and `ctl_data[6]` at 0. A write with only one of those bits at 0, or those bits at 0 with `ctl_wr` low, has no effect on the window.
- R2: A strobe condition held for several consecutive cycles counts as a single strobe, taken on its first cycle.
- R3: Let W be the number of clock edges since the last accepted strobe edge, or since reset release, with the first edge counting as 0. A strobe seen with MIN_CYC <= W <= MAX_CYC-1 is accepted and restarts the window. The first window starts at reset release.
- R4: A strobe seen with W < MIN_CYC latches a fault and sets `fault_cause` to 2'b01. This includes a strobe on the very first edge after reset.
- R5: If the edge with W = MAX_CYC-1 passes with no strobe, a fault is latched and `fault_cause` is set to 2'b10.
- R6: Once a fault is latched, later strobes, whether early, valid or late, do not clear it. `fault_cause` keeps the value of the first failure.
- R7: `fault_int_n` is driven from a register. It is low from the cycle after the failing edge until reset.
- R8: `fail_n` goes low exactly one cycle after `fault_int_n` goes low, and it stays low until reset.
- R9: `bv_en` equals `bv_req` and `wg_en` equals `wg_req` while `fail_n` is high. Both enables are 0 while `fail_n` is low.
- R10: A synchronous active-high `rst` clears the fault. Every cycle after a reset edge shows `fault_int_n`=1, `fail_n`=1 and `fault_cause`=2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write enable |
| ctl_data | input | 8 | Control register write data; bits 5 and 6 both low form the strobe |
| bv_req | input | 1 | Base voltage generator enable request |
| wg_req | input | 1 | Waveform generator enable request |
| fault_int_n | output | 1 | Active-low watchdog interrupt |
| fail_n | output | 1 | Active-low fail line, one cycle after the interrupt |
| fault_cause | output | 2 | 00 none, 01 early strobe, 10 late or missing strobe |
| bv_en | output | 1 | Gated base voltage generator enable |
| wg_en | output | 1 | Gated waveform generator enable |

## Verification
A window counter that is off by one shows at the ports on the boundary strobes. A strobe taken exactly at MIN_CYC would then fault early, or a quiet period of exactly MAX_CYC edges would pass without a fault, and `fault_int_n` would be wrong one cycle after that edge. A broken edge detector turns a held strobe into a second, early strobe, which faults on the next cycle. A fault latch that fails to hold shows as `fault_int_n` or `fault_cause` changing back when a later strobe arrives. A missing fail stage shows as `fail_n` or the gated enables failing to follow the interrupt one cycle later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EARLY = 2'b01,
    CAUSE_LATE  = 2'b10
  } cause_e;
endpackage

// File: rtl/wdog_strobe_dec.sv
// Decodes the strobe from a control write and keeps only its first cycle.
module wdog_strobe_dec #(
  parameter int CTL_W = 8,
  parameter int BIT_A = 5,
  parameter int BIT_B = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] data,
  output logic             stb_evt
);
  logic dec;
  logic dec_q;

  assign dec = wr && !data[BIT_A] && !data[BIT_B];

  always_ff @(posedge clk) begin
    if (rst) dec_q <= 1'b0;
    else     dec_q <= dec;
  end

  assign stb_evt = dec && !dec_q;
endmodule

// File: rtl/wdog_window_timer.sv
// Counts edges since the last accepted strobe and judges each strobe against the window.
module wdog_window_timer #(
  parameter int MIN_CYC = 16,
  parameter int MAX_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_evt,
  input  logic freeze,
  output logic early_hit,
  output logic late_hit
);
  localparam int CNT_W = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_CYC);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign early_hit = stb_evt && (cnt < MIN_V);
  assign late_hit  = !stb_evt && (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!freeze) begin
      if (stb_evt)         cnt <= '0;
      else if (!late_hit)  cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_fault_latch.sv
// Latches the first failure, raises the interrupt, then the fail line, and gates the enables.
module wdog_fault_latch #(
  parameter int N_GEN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                early_hit,
  input  logic                late_hit,
  input  logic [N_GEN-1:0]    gen_req,
  output logic                fault_q,
  output logic                fault_int_n,
  output logic                fail_n,
  output wdog_pkg::cause_e    cause,
  output logic [N_GEN-1:0]    gen_en
);
  import wdog_pkg::*;

  logic   fail_q;
  cause_e cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      fail_q  <= 1'b0;
    end else begin
      fail_q <= fault_q;
      if (!fault_q) begin
        if (early_hit) begin
          fault_q <= 1'b1;
          cause_q <= CAUSE_EARLY;
        end else if (late_hit) begin
          fault_q <= 1'b1;
          cause_q <= CAUSE_LATE;
        end
      end
    end
  end

  assign fault_int_n = !fault_q;
  assign fail_n      = !fail_q;
  assign cause       = cause_q;

  for (genvar g = 0; g < N_GEN; g++) begin : g_gate
    assign gen_en[g] = gen_req[g] && !fail_q;
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int MIN_CYC = 16,
  parameter int MAX_CYC = 64,
  parameter int CTL_W   = 8,
  parameter int STB_A   = 5,
  parameter int STB_B   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic             bv_req,
  input  logic             wg_req,
  output logic             fault_int_n,
  output logic             fail_n,
  output logic [1:0]       fault_cause,
  output logic             bv_en,
  output logic             wg_en
);
  localparam int N_GEN = 2;

  logic             stb_evt;
  logic             early_hit;
  logic             late_hit;
  logic             fault_q;
  wdog_pkg::cause_e cause;
  logic [N_GEN-1:0] gen_en;

  wdog_strobe_dec #(.CTL_W(CTL_W), .BIT_A(STB_A), .BIT_B(STB_B)) u_dec (
    .clk(clk), .rst(rst), .wr(ctl_wr), .data(ctl_data), .stb_evt(stb_evt)
  );

  wdog_window_timer #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_timer (
    .clk(clk), .rst(rst), .stb_evt(stb_evt), .freeze(fault_q),
    .early_hit(early_hit), .late_hit(late_hit)
  );

  wdog_fault_latch #(.N_GEN(N_GEN)) u_latch (
    .clk(clk), .rst(rst), .early_hit(early_hit), .late_hit(late_hit),
    .gen_req({wg_req, bv_req}), .fault_q(fault_q), .fault_int_n(fault_int_n),
    .fail_n(fail_n), .cause(cause), .gen_en(gen_en)
  );

  assign fault_cause = cause;
  assign bv_en       = gen_en[0];
  assign wg_en       = gen_en[1];
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk (
  input logic       clk,
  input logic       rst,
  input logic       fault_int_n,
  input logic       fail_n,
  input logic [1:0] fault_cause,
  input logic       bv_en,
  input logic       wg_en
);
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !fault_int_n |=> !fault_int_n);  // R6
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    !fault_int_n |=> $stable(fault_cause));  // R6
  AST_FAIL_LAGS: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_int_n) |=> $fell(fail_n));  // R8
  AST_FAIL_NEEDS_INT: assert property (@(posedge clk) disable iff (rst)
    !fail_n |-> !fault_int_n);  // R8
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !fail_n |-> (!bv_en && !wg_en));  // R9
  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_cause) && (fault_int_n == (fault_cause == 2'b00)));  // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (fault_int_n && fail_n && fault_cause == 2'b00));  // R10
endmodule

bind wdog_window wdog_window_chk u_chk (
  .clk(clk), .rst(rst), .fault_int_n(fault_int_n), .fail_n(fail_n),
  .fault_cause(fault_cause), .bv_en(bv_en), .wg_en(wg_en)
);

// File: tb/wdog_window_bench.sv
module wdog_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIN = 16;
  localparam int MAX = 64;
  localparam int BA = 5;
  localparam int BB = 6;
  localparam logic [7:0] STB_CODE = 8'h9F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 1'b0;
  logic [7:0] ctl_data = 8'hFF;
  logic bv_req = 1'b0;
  logic wg_req = 1'b0;
  logic fault_int_n, fail_n, bv_en, wg_en;
  logic [1:0] fault_cause;

  wdog_window #(.MIN_CYC(MIN), .MAX_CYC(MAX)) u_wdog_window (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .bv_req(bv_req), .wg_req(wg_req), .fault_int_n(fault_int_n),
    .fail_n(fail_n), .fault_cause(fault_cause), .bv_en(bv_en), .wg_en(wg_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       int_n;
    logic       fail_n;
    logic [1:0] cause;
    logic       bv;
    logic       wg;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int cyc_no = 0;
  bit finished = 0;

  int       m_cnt = 0;
  bit       m_fault = 0;
  bit       m_fail = 0;
  bit       m_decq = 0;
  logic [1:0] m_cause = 2'b00;

  task automatic cyc(input bit r, input bit wr, input logic [7:0] d, input string tag);
    exp_t e;
    bit dec;
    bit evt;
    bit old_fault;
    @(negedge clk);
    cyc_no++;
    rst = r; ctl_wr = wr; ctl_data = d;
    bv_req = cyc_no[3];
    wg_req = cyc_no[4];
    if (r) begin
      m_cnt = 0; m_fault = 0; m_fail = 0; m_decq = 0; m_cause = 2'b00;
    end else begin
      dec = wr && !d[BA] && !d[BB];
      evt = dec && !m_decq;
      m_decq = dec;
      old_fault = m_fault;
      if (!m_fault) begin
        if (evt) begin
          if (m_cnt < MIN) begin m_fault = 1; m_cause = 2'b01; end
          else m_cnt = 0;
        end else if (m_cnt == MAX-1) begin
          m_fault = 1; m_cause = 2'b10;
        end else begin
          m_cnt++;
        end
      end
      m_fail = old_fault;
    end
    e.int_n = !m_fault;
    e.fail_n = !m_fail;
    e.cause = m_cause;
    e.bv = bv_req && !m_fail;
    e.wg = wg_req && !m_fail;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'hFF, tag);
  endtask

  task automatic strobe(input string tag);
    cyc(0, 1, STB_CODE, tag);
  endtask

  task automatic do_reset(input string tag);
    for (int i = 0; i < 3; i++) cyc(1, 0, 8'hFF, tag);
  endtask

  task automatic cmp(input string req, input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) cycle %0d: actual %0b expected %0b", req, tag, cyc_no, act, exp);
    end
  endtask

  // Monitor: pops one expectation per edge and compares away from the edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        cmp("R7 fault_int_n", e.tag, {1'b0, fault_int_n}, {1'b0, e.int_n});
        cmp("R8 fail_n", e.tag, {1'b0, fail_n}, {1'b0, e.fail_n});
        cmp("R4/R5 fault_cause", e.tag, fault_cause, e.cause);
        cmp("R9 bv_en", e.tag, {1'b0, bv_en}, {1'b0, e.bv});
        cmp("R9 wg_en", e.tag, {1'b0, wg_en}, {1'b0, e.wg});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    do_reset("R10 power-on reset");
    // R3: accepted strobes at the lower and upper window edges
    idle(MIN, "R3 wait min");
    strobe("R3 strobe at min");
    // R1: near-miss writes act as idle cycles
    cyc(0, 1, 8'hDF, "R1 bit6 high");
    cyc(0, 1, 8'hBF, "R1 bit5 high");
    cyc(0, 0, STB_CODE, "R1 no write");
    idle(MIN-3, "R1 filler");
    strobe("R1 valid strobe after near-misses");
    // R2: a held strobe counts once
    idle(MIN, "R2 wait");
    strobe("R2 held first");
    strobe("R2 held second");
    strobe("R2 held third");
    idle(MIN-2, "R2 filler");
    strobe("R2 valid after hold");
    idle(MAX-1, "R3 wait max-1");
    strobe("R3 strobe at max-1");
    idle(30, "R3 mid window");
    strobe("R3 strobe mid");
    // R4: early strobe
    idle(MIN-1, "R4 wait min-1");
    strobe("R4 early strobe");
    // R6: later strobes cannot clear
    idle(5, "R6 after early");
    strobe("R6 strobe after fault");
    idle(MAX+2, "R6 long wait");
    strobe("R6 late strobe after fault");
    idle(3, "R6 hold");
    do_reset("R10 clear after early");
    // R5: missing strobe, window edge exactly at MAX
    idle(MAX, "R5 silent window");
    strobe("R6 strobe after late fault");
    idle(4, "R6 hold late");
    do_reset("R10 clear after late");
    // R4: strobe on the first edge after reset
    strobe("R4 strobe at zero");
    idle(3, "R6 hold zero");
    do_reset("R10 clear again");
    idle(MIN+4, "R3 final wait");
    strobe("R3 final strobe");
    idle(4, "R3 tail");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule